// File: doc/BRIEF.md
# Alternating-Drive Column Level Selector

This block is the output stage of a column (segment) driver for a dot-matrix liquid crystal panel. An upstream capture stage fills a line-wide register with pixel bits. On each falling edge of a line-latch strobe, this block copies that line into its own hold register. For every column it then produces a 2-bit code that names one of four drive levels. The code depends on the held pixel bit and on a frame-polarity input that reverses each frame, so that the panel sees an alternating drive with no DC component.

An active-low display-off input forces every column to the second level, which is the lowest voltage. This input takes priority over the held data and the polarity input. During power-up it is held low while a frame of lines is clocked in. The line register keeps loading while the display is off, so the panel shows a valid line as soon as display-off is released.

The line-latch strobe is slow compared with the system clock, so the block samples it with that clock and detects its falling edge synchronously. The polarity and display-off inputs act on the outputs combinationally.

Top module: `segLevelSelect`

## Requirements
- R1: On the first rising edge of `clk` where `lineClk` is sampled low after being sampled high, the hold register copies all of `captureLine`. The new codes appear after that edge.
- R2: At any other time the hold register keeps its contents. Changes on `captureLine` and rising edges of `lineClk` have no effect on `levelOut`.
- R3: With `dispOnN` high and `frameM` high, a held 1 gives code 2'b00 (level V1, selected) and a held 0 gives code 2'b10 (level V3, non-selected).
- R4: With `dispOnN` high and `frameM` low, a held 1 gives code 2'b01 (level V2, selected) and a held 0 gives code 2'b11 (level V4, non-selected).
- R5: A change on `frameM` alters `levelOut` in the same cycle, without a latch edge.
- R6: While `dispOnN` is low, every column outputs code 2'b01 (V2), whatever the held data and `frameM` are.
- R7: Line loads continue while `dispOnN` is low. When it is released, `levelOut` shows the last line loaded.
- R8: Reset clears the hold register to all zeros. With `frameM` high after reset, every column reads 2'b10.
- R9: Column i takes its pixel from `captureLine[i]` and drives its code on `levelOut[2*i+1:2*i]`, for i from 0 to COLS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineClk | input | 1 | Line-latch strobe; its falling edge loads a line |
| captureLine | input | COLS | Pixel bits from the capture register, one per column |
| frameM | input | 1 | Frame-polarity input |
| dispOnN | input | 1 | Active-low display-off; forces code V2 on all columns |
| levelOut | output | 2*COLS | Packed 2-bit drive-level codes, column 0 in the low bits |

## Verification
A hold register that loads at the wrong time or misses a load shows up at the first check after a line-latch fall. At that point the whole 480-bit code vector is compared against a model line, so a missing, doubled or early load is seen within one cycle. A wrong column mapping or a swapped level code appears in a column whose bit differs from its neighbours. The test patterns are asymmetric, and they include the first and last columns. A weakened display-off priority is exposed by toggling polarity and loading new lines while display-off is held. Each of those cycles is compared against the all-V2 vector.

// File: rtl/segLevelPkg.sv
package segLevelPkg;
  // drive level codes; bit1 set = non-selected, bit0 set = negative frame
  typedef enum logic [1:0] {
    LVL_V1 = 2'b00,
    LVL_V2 = 2'b01,
    LVL_V3 = 2'b10,
    LVL_V4 = 2'b11
  } levelCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLine;
    logic forceOff;
  } lineCtl_t;
endpackage

// File: rtl/segLineCtl.sv
module segLineCtl
  import segLevelPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineClk,
  input  logic     dispOnN,
  output lineCtl_t ctl
);
  logic lineClkQ;

  always_ff @(posedge clk) begin
    if (!rstN) lineClkQ <= 1'b0;
    else       lineClkQ <= lineClk;
  end

  always_comb begin
    ctl.loadLine = lineClkQ & ~lineClk;
    ctl.forceOff = ~dispOnN;
  end

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLine |=> !ctl.loadLine); // R1
endmodule

// File: rtl/segLineData.sv
module segLineData
  import segLevelPkg::*;
#(
  parameter int COLS = 240
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lineCtl_t                  ctl,
  input  logic [COLS-1:0]           captureLine,
  input  logic                      frameM,
  output logic [COLS*$bits(levelCode_e)-1:0] levelOut
);
  localparam int CODE_W = $bits(levelCode_e);

  logic [COLS-1:0] lineQ;

  always_ff @(posedge clk) begin
    if (!rstN)             lineQ <= '0;
    else if (ctl.loadLine) lineQ <= captureLine;
  end

  for (genvar i = 0; i < COLS; i++) begin : g_col
    levelCode_e colCode;
    always_comb begin
      if (ctl.forceOff)  colCode = LVL_V2;
      else if (frameM)   colCode = lineQ[i] ? LVL_V1 : LVL_V3;
      else               colCode = lineQ[i] ? LVL_V2 : LVL_V4;
    end
    assign levelOut[i*CODE_W +: CODE_W] = colCode;
  end

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLine |=> lineQ == $past(captureLine)); // R1
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadLine |=> $stable(lineQ)); // R2
  AST_OFF_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceOff |-> levelOut == {COLS{LVL_V2}}); // R6
endmodule

// File: rtl/segLevelSelect.sv
module segLevelSelect
  import segLevelPkg::*;
#(
  parameter int COLS = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineClk,
  input  logic [COLS-1:0]   captureLine,
  input  logic              frameM,
  input  logic              dispOnN,
  output logic [2*COLS-1:0] levelOut
);
  lineCtl_t ctl;

  segLineCtl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .lineClk (lineClk),
    .dispOnN (dispOnN),
    .ctl     (ctl)
  );

  segLineData #(.COLS(COLS)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .captureLine (captureLine),
    .frameM      (frameM),
    .levelOut    (levelOut)
  );

  AST_OFF_PORTS: assert property (@(posedge clk) disable iff (!rstN)
    !dispOnN |-> levelOut == {COLS{2'b01}}); // R6
endmodule

// File: tb/segLevelSelect_tb.sv
module segLevelSelect_tb;
  localparam int COLS = 240;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lineClk = 1'b0;
  logic [COLS-1:0]   captureLine = '0;
  logic              frameM = 1'b1;
  logic              dispOnN = 1'b1;
  logic [2*COLS-1:0] levelOut;

  int checks = 0;
  int errors = 0;
  logic [COLS-1:0] model = '0;

  always #5 clk = ~clk;

  segLevelSelect #(.COLS(COLS)) u_dut (
    .clk(clk), .rstN(rstN), .lineClk(lineClk), .captureLine(captureLine),
    .frameM(frameM), .dispOnN(dispOnN), .levelOut(levelOut)
  );

  function automatic logic [2*COLS-1:0] expVec(logic [COLS-1:0] ln, logic m, logic on);
    logic [2*COLS-1:0] v;
    for (int i = 0; i < COLS; i++) begin
      if (!on)   v[2*i +: 2] = 2'b01;
      else if (m) v[2*i +: 2] = ln[i] ? 2'b00 : 2'b10;
      else        v[2*i +: 2] = ln[i] ? 2'b01 : 2'b11;
    end
    return v;
  endfunction

  function automatic logic [COLS-1:0] makePat(int kind);
    logic [COLS-1:0] p;
    for (int i = 0; i < COLS; i++)
      case (kind)
        0: p[i] = (i % 3 == 0) || (i == COLS-1);
        1: p[i] = ((i * 7) % 5) < 2;
        2: p[i] = 1'b1;
        default: p[i] = (i == 0) || (i == COLS-1);
      endcase
    return p;
  endfunction

  task automatic checkOut(string req, logic [COLS-1:0] ln, logic m, logic on);
    logic [2*COLS-1:0] e;
    e = expVec(ln, m, on);
    checks++;
    if (levelOut !== e) begin
      errors++;
      for (int i = 0; i < COLS; i++)
        if (levelOut[2*i +: 2] !== e[2*i +: 2]) begin
          $display("FAIL %s column %0d actual %b expected %b", req, i,
                   levelOut[2*i +: 2], e[2*i +: 2]);
          break;
        end
    end
  endtask

  // drive a full high-then-low strobe; load lands on the edge after the fall
  task automatic lineFall(logic [COLS-1:0] ln);
    @(negedge clk); captureLine = ln; lineClk = 1'b1;
    @(negedge clk); lineClk = 1'b0;
    @(negedge clk);
    model = ln;
  endtask

  task automatic testReset();
    @(negedge clk);
    checkOut("R8", '0, 1'b1, 1'b1);
  endtask

  task automatic testLoadPolarity();
    lineFall(makePat(0));
    checkOut("R1 R3 R9", model, 1'b1, 1'b1);
    frameM = 1'b0; #1;
    checkOut("R5 R4", model, 1'b0, 1'b1);
    @(negedge clk);
    checkOut("R4 R9", model, 1'b0, 1'b1);
    frameM = 1'b1; #1;
    checkOut("R5 R3", model, 1'b1, 1'b1);
  endtask

  task automatic testHold();
    @(negedge clk); captureLine = makePat(1);
    @(negedge clk); @(negedge clk);
    checkOut("R2 capture change", model, 1'b1, 1'b1);
    lineClk = 1'b1;
    @(negedge clk); @(negedge clk);
    checkOut("R2 rising strobe", model, 1'b1, 1'b1);
    lineClk = 1'b0;
    @(negedge clk);
    model = makePat(1);
    checkOut("R1 delayed fall", model, 1'b1, 1'b1);
  endtask

  task automatic testDisplayOff();
    dispOnN = 1'b0; #1;
    checkOut("R6 off", model, 1'b1, 1'b0);
    frameM = 1'b0; #1;
    checkOut("R6 off polarity", model, 1'b0, 1'b0);
    lineFall(makePat(2));
    checkOut("R6 R7 load while off", model, 1'b0, 1'b0);
    lineFall(makePat(3));
    frameM = 1'b1; #1;
    checkOut("R6 second load", model, 1'b1, 1'b0);
    dispOnN = 1'b1; #1;
    checkOut("R7 release", model, 1'b1, 1'b1);
    frameM = 1'b0; #1;
    checkOut("R7 R4 edges", model, 1'b0, 1'b1);
  endtask

  task automatic testExtremes();
    lineFall('0);
    checkOut("R4 all zero", model, 1'b0, 1'b1);
    lineFall(makePat(2));
    frameM = 1'b1; #1;
    checkOut("R3 all one", model, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLoadPolarity();
    testHold();
    testDisplayOff();
    testExtremes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule